// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers 32 peripheral interrupt sources into one request line for a parent interrupt controller. Software reaches it through a plain register port: an address, a write enable, write data, and read data that reflects the addressed register in the same cycle. Each source has its own enable bit. That bit is never written directly. Software sets it through a write-ones-to-set register and clears it through a separate write-ones-to-clear register, and it can read back the current value.

A build-time parameter selects one of two flavours. The latched flavour records each rising edge of a source in a sticky pending register, which software acknowledges one bit at a time by writing ones. The level flavour has no pending storage: the status it shows is the live source inputs, and it has no acknowledge register. The register layout differs between the two flavours. The parent line is a registered function of the pending and mask state.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the mask reads all ones (every source disabled), the latched status reads zero and `parentIrq` is low.
- R2: A write to the mask-set register (byte offset 0x10 latched, 0x08 level) sets the mask bits written as 1 and leaves bits written as 0 unchanged. An all-ones write disables every source at once.
- R3: A write to the mask-clear register (offset 0x14 latched, 0x0C level) clears the mask bits written as 1 and leaves the others unchanged.
- R4: The current mask reads back at offset 0x0C in latched mode and at offset 0x04 in level mode. A mask bit of 1 means the source is disabled.
- R5: In latched mode, a rising edge on a source sets its status bit (read at offset 0x00), and the bit stays set until acknowledged. This happens even while the source is masked.
- R6: In latched mode, writing 1s to the acknowledge register at offset 0x08 clears those status bits, and bits written as 0 have no effect.
- R7: In latched mode, if a new rising edge and an acknowledge of the same bit land in the same cycle, the bit stays set.
- R8: In level mode, status at offset 0x00 equals the live source inputs, and writes to that offset change nothing.
- R9: `parentIrq` equals the OR of (status AND NOT mask), taken one clock after the state it reflects.
- R10: Reads of any offset that is not a status or mask-status register return zero. This includes the write-only set, clear and acknowledge registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIrq | input | 32 | Peripheral interrupt sources, one bit per source |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe for the addressed register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register, combinational |
| parentIrq | output | 1 | Registered request to the parent controller |

## Verification
The bench latches an edge on a source that is masked and checks two things: the parent line stays low, and it rises exactly one cycle after the source is unmasked. A design that gated capture by the mask would drop this event, and one with an unregistered output would respond a cycle early. It also acknowledges a bit in the same cycle as a fresh edge on that bit. A design that let the acknowledge win would lose the new event. In both modes the bench writes zero bits to the set, clear and acknowledge registers, writes to the status offset in level mode, and reads the write-only and unmapped offsets. A design with a full-word mask write, a live acknowledge in level mode, or readable strobe registers would show the wrong value on the read port.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  typedef struct packed {
    logic ackWr;
    logic maskSetWr;
    logic maskClrWr;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } rdSel_t;
endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobe_t       strobe,
  output rdSel_t            rdSel
);
  localparam logic [ADDR_W-1:0] OFF_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_ACK    = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_MASK   = LATCHED ? ADDR_W'(12) : ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_SET    = LATCHED ? ADDR_W'(16) : ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_CLR    = LATCHED ? ADDR_W'(20) : ADDR_W'(12);

  always_comb begin
    strobe = '0;
    rdSel  = RD_ZERO;
    if (busAddr == OFF_STATUS) rdSel = RD_STATUS;
    if (busAddr == OFF_MASK)   rdSel = RD_MASK;
    if (busWe) begin
      strobe.maskSetWr = (busAddr == OFF_SET);
      strobe.maskClrWr = (busAddr == OFF_CLR);
      strobe.ackWr     = LATCHED && (busAddr == OFF_ACK);
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ackWr, strobe.maskSetWr, strobe.maskClrWr}));
endmodule

// File: rtl/irqagg_datapath.sv
module irqagg_datapath
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  ctrlStrobe_t        strobe,
  input  rdSel_t             rdSel,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic               parentIrq
);
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] maskQ;
  logic               parentQ;

  if (LATCHED) begin : g_latched
    logic [NUM_SRC-1:0] srcPrev;
    logic [NUM_SRC-1:0] statusQ;
    logic [NUM_SRC-1:0] riseEdge;
    logic [NUM_SRC-1:0] ackBits;

    assign riseEdge = srcIrq & ~srcPrev;
    assign ackBits  = strobe.ackWr ? busWdata : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcPrev <= '0;
        statusQ <= '0;
      end else begin
        srcPrev <= srcIrq;
        // a fresh edge outranks an acknowledge of the same bit
        statusQ <= (statusQ & ~ackBits) | riseEdge;
      end
    end
    assign status = statusQ;

    // R5
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.ackWr |=> (($past(statusQ) & ~statusQ) == '0));
  end else begin : g_level
    assign status = srcIrq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '1;
      parentQ <= 1'b0;
    end else begin
      if (strobe.maskSetWr)      maskQ <= maskQ | busWdata;
      else if (strobe.maskClrWr) maskQ <= maskQ & ~busWdata;
      parentQ <= |(status & ~maskQ);
    end
  end

  assign parentIrq = parentQ;

  always_comb begin
    unique case (rdSel)
      RD_STATUS: busRdata = status;
      RD_MASK:   busRdata = maskQ;
      default:   busRdata = '0;
    endcase
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSetWr |=> ((maskQ & $past(busWdata)) == $past(busWdata)));
  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskClrWr |=> ((maskQ & $past(busWdata)) == '0));
  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.maskSetWr || strobe.maskClrWr) |=> $stable(maskQ));
  // R9
  parent_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((maskQ == '1) && ($past(maskQ) == '1)) |-> !parentIrq);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic               parentIrq
);
  ctrlStrobe_t strobe;
  rdSel_t      rdSel;

  irqagg_ctrl #(.ADDR_W(ADDR_W), .LATCHED(LATCHED)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .strobe(strobe), .rdSel(rdSel)
  );

  irqagg_datapath #(.NUM_SRC(NUM_SRC), .LATCHED(LATCHED)) u_dp (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .strobe(strobe), .rdSel(rdSel),
    .busWdata(busWdata), .busRdata(busRdata), .parentIrq(parentIrq)
  );
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] srcA = '0, srcB = '0;
  logic [7:0]  addrA = '0, addrB = '0;
  logic        weA = 1'b0, weB = 1'b0;
  logic [31:0] wdA = '0, wdB = '0;
  logic [31:0] rdA, rdB;
  logic        irqA, irqB;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  irq_aggregator #(.LATCHED(1'b1)) uut (
    .clk(clk), .rstN(rstN), .srcIrq(srcA), .busAddr(addrA), .busWe(weA),
    .busWdata(wdA), .busRdata(rdA), .parentIrq(irqA));

  irq_aggregator #(.LATCHED(1'b0)) uutLevel (
    .clk(clk), .rstN(rstN), .srcIrq(srcB), .busAddr(addrB), .busWe(weB),
    .busWdata(wdB), .busRdata(rdB), .parentIrq(irqB));

  // {source pattern, acknowledge write, expected status}
  localparam logic [95:0] VEC [0:5] = '{
    {32'h0000_000F, 32'h0000_0000, 32'h0000_000F},
    {32'h0000_00F0, 32'h0000_0003, 32'h0000_00FC},
    {32'h0000_00F0, 32'hFFFF_FF00, 32'h0000_00FC},
    {32'h8000_0001, 32'h0000_00FC, 32'h8000_0001},
    {32'h0000_0000, 32'h8000_0001, 32'h0000_0000},
    {32'hA5A5_0000, 32'h0000_FFFF, 32'hA5A5_0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit lvl, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    if (lvl) begin addrB = a; wdB = d; weB = 1'b1; end
    else     begin addrA = a; wdA = d; weA = 1'b1; end
    @(negedge clk);
    weA = 1'b0; weB = 1'b0;
  endtask

  task automatic rd(input bit lvl, input logic [7:0] a, output logic [31:0] d);
    if (lvl) addrB = a; else addrA = a;
    #1;
    d = lvl ? rdB : rdA;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, 8'h0C, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(0, 8'h00, v); chk("R1 status", v, 32'h0);
    chk("R1 parent", {31'b0, irqA}, 32'h0);

    // R5 edge latches while masked, R9 stays low
    srcA = 32'h1;
    @(negedge clk);
    rd(0, 8'h00, v); chk("R5 masked latch", v, 32'h1);
    @(negedge clk);
    chk("R9 masked parent low", {31'b0, irqA}, 32'h0);

    // R3 unmask bit0, R9 rises one cycle later
    wr(0, 8'h14, 32'h1);
    rd(0, 8'h0C, v); chk("R3 clear bit0", v, 32'hFFFF_FFFE);
    chk("R9 not yet", {31'b0, irqA}, 32'h0);
    @(negedge clk);
    chk("R9 parent rises", {31'b0, irqA}, 32'h1);

    // R2 set with zeros preserving
    wr(0, 8'h14, 32'hFFFF_FFFF);
    wr(0, 8'h10, 32'h0000_0F0F);
    rd(0, 8'h0C, v); chk("R2 partial set", v, 32'h0000_0F0F);
    wr(0, 8'h10, 32'hFFFF_FFFF);
    rd(0, 8'h0C, v); chk("R2 all ones", v, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R9 all masked", {31'b0, irqA}, 32'h0);

    // R6 acknowledge with held source: no re-latch
    wr(0, 8'h08, 32'h1);
    rd(0, 8'h00, v); chk("R6 ack bit0", v, 32'h0);
    srcA = 32'h0;
    wr(0, 8'h14, 32'hFFFF_FFFF);

    // table: R5 capture, R6 acknowledge, R9 parent
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      srcA = VEC[i][95:64];
      @(negedge clk);
      wr(0, 8'h08, VEC[i][63:32]);
      rd(0, 8'h00, v); chk("R6 table status", v, VEC[i][31:0]);
      @(negedge clk);
      chk("R9 table parent", {31'b0, irqA}, {31'b0, (VEC[i][31:0] != 0)});
    end

    // R7 new edge wins over same-cycle acknowledge
    srcA = 32'h0;
    @(negedge clk);
    srcA = 32'h0001_0000; addrA = 8'h08; wdA = 32'hA5A5_0000; weA = 1'b1;
    @(negedge clk);
    weA = 1'b0;
    rd(0, 8'h00, v); chk("R7 edge beats ack", v, 32'h0001_0000);

    // R10 unmapped and write-only reads
    rd(0, 8'h04, v); chk("R10 latched 0x04", v, 32'h0);
    rd(0, 8'h08, v); chk("R10 latched ack reg", v, 32'h0);
    rd(0, 8'h10, v); chk("R10 latched set reg", v, 32'h0);
    rd(0, 8'h18, v); chk("R10 latched 0x18", v, 32'h0);

    // level mode: R4 mask offset, R8 live status
    rd(1, 8'h04, v); chk("R4 level reset mask", v, 32'hFFFF_FFFF);
    srcB = 32'h0000_1234;
    rd(1, 8'h00, v); chk("R8 live status", v, 32'h0000_1234);
    wr(1, 8'h00, 32'hFFFF_FFFF);
    rd(1, 8'h00, v); chk("R8 status write ignored", v, 32'h0000_1234);
    wr(1, 8'h0C, 32'h0000_0004);
    rd(1, 8'h04, v); chk("R4 level mask readback", v, 32'hFFFF_FFFB);
    @(negedge clk);
    chk("R9 level parent", {31'b0, irqB}, 32'h1);
    srcB = 32'h0;
    @(negedge clk);
    chk("R8 level no latch", {31'b0, irqB}, 32'h0);
    wr(1, 8'h08, 32'h0000_0004);
    rd(1, 8'h04, v); chk("R2 level set", v, 32'hFFFF_FFFF);
    rd(1, 8'h14, v); chk("R10 level 0x14", v, 32'h0);
    rd(1, 8'h0C, v); chk("R10 level clr reg", v, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule